// File: doc/BRIEF.md
# Pulse Interrupt Aggregator with End-of-Interrupt Re-arm

This block merges three pending-interrupt inputs into one pulse interrupt line. Each source has an enable bit. Software sets enables by writing ones to one address and clears them by writing ones to a second address. A source counts as active when its pending input and its enable are both high. When any source is active and the block is armed, the output carries a single-cycle pulse and the block disarms.

After servicing, software writes the end-of-interrupt register to re-arm the output. If any source is still active at that point, or became active while the handler ran, a new pulse follows at once. Software can also read a status word, a vector word that names the lowest active source, and a fixed revision word. All of this goes through a small synchronous register port with a registered read path.

The three sources sit at fixed bit positions: bit 0 is the event source, bit 1 is the management-interface source and bit 2 is the statistics source.

Top module: `pulse_irq_agg`

## Requirements
- R1: After synchronous reset, the enables, the stored end-of-interrupt field, the status word, both vector words and the read data are 0. The pulse output is low and the block is armed.
- R2: A write to offset 0x100 sets enable bit i for each i in 0..2 where write-data bit i is 1. Zero bits leave their enable unchanged. A read of 0x100 returns the enables in bits 2:0 and zeros above.
- R3: A write to offset 0x300 clears enable bit i for each i where write-data bit i is 1. A read of 0x300 returns the enables in bits 2:0.
- R4: A read of offset 0x500 returns, in bit i, pending input i ANDed with enable i, with bits 31:3 zero.
- R5: When the block is armed and the enabled status is nonzero at a clock edge, the pulse output is high for exactly the following cycle and the block disarms. While disarmed, no further pulse is produced.
- R6: A write to offset 0x010 stores write-data bits 7:0, which read back in bits 7:0 with zeros above, and re-arms the block. If the enabled status is nonzero at the next edge, a pulse follows in the cycle after that edge.
- R7: Reads of offsets 0x014 and 0xA80 both return the lowest index i with an active enabled source, plus one (1 for event, 2 for management, 3 for statistics), or 0 when none is active.
- R8: A read of offset 0x000 returns 0x6690A200.
- R9: Reads of any other offset return 0. Writes to any other offset change no enable, no stored field and no arm state.
- R10: Read data is registered. The value seen after an edge reflects the address presented and the state held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | 3 | Raw pending inputs: bit 0 event, bit 1 management, bit 2 statistics |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_pulse | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench aims at the arm/disarm boundary.
- End-of-interrupt writes that land while status is still pending must produce a second pulse one cycle later. A design that missed the re-arm would stay silent.
- Writes that arrive while the pulse is being generated must not trigger anything early. A design that re-armed on its own would pulse repeatedly.

Random writes with mixed one and zero bits go to both enable aliases. A design that treated zeros as clears, or wrote the aliases plainly, would lose enables that were already set.

Random pending patterns with two or three sources active check that the vector word picks the lowest index and not the highest. Writes to unmapped offsets check that no enable or arm state is disturbed.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam logic [11:0] OFF_REV   = 12'h000;
  localparam logic [11:0] OFF_EOI   = 12'h010;
  localparam logic [11:0] OFF_VEC   = 12'h014;
  localparam logic [11:0] OFF_ENSET = 12'h100;
  localparam logic [11:0] OFF_ENCLR = 12'h300;
  localparam logic [11:0] OFF_STAT  = 12'h500;
  localparam logic [11:0] OFF_VECP  = 12'hA80;
  localparam logic [31:0] REV_WORD  = {2'd1, 2'd2, 12'h690, 5'h14, 3'd2, 2'd0, 6'd0};
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] en
);
  always_ff @(posedge clk) begin
    if (rst) en <= '0;
    else if (set_we) en <= en | wbits;
    else if (clr_we) en <= en & ~wbits;
  end

  a_r2_set_bits_stick: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en & $past(wbits)) == $past(wbits)));
  a_r2_zero_bits_keep: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((en & $past(en)) == $past(en)));
  a_r3_clear_bits_drop: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((en & $past(wbits)) == '0));
  a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(en));
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc #(
  parameter int NSRC = 3,
  parameter int VW   = 32
) (
  input  logic [NSRC-1:0] active,
  output logic [VW-1:0]   vec
);
  always_comb begin
    vec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (active[i]) vec = VW'(i + 1);
    end
  end
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] status,
  input  logic            eoi_we,
  output logic            irq_pulse
);
  logic armed;
  logic fire;

  assign fire = armed && (status != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b1;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= fire;
      if (fire)        armed <= 1'b0;
      else if (eoi_we) armed <= 1'b1;
    end
  end

  a_r5_single_cycle: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  a_r5_needs_status: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(status != '0));
  a_r6_rearm_then_fire: assert property (@(posedge clk) disable iff (rst)
    (eoi_we && !irq_pulse && !fire) ##1 (status != '0) |=> irq_pulse);
endmodule

// File: rtl/pulse_irq_agg.sv
module pulse_irq_agg
  import pirq_pkg::*;
#(
  parameter int NSRC = 3,
  parameter int AW   = 12,
  parameter int DW   = 32,
  parameter int EOIW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_pend,
  input  logic            reg_wen,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  output logic            irq_pulse
);
  localparam logic [AW-1:0] A_REV   = AW'(OFF_REV);
  localparam logic [AW-1:0] A_EOI   = AW'(OFF_EOI);
  localparam logic [AW-1:0] A_VEC   = AW'(OFF_VEC);
  localparam logic [AW-1:0] A_ENSET = AW'(OFF_ENSET);
  localparam logic [AW-1:0] A_ENCLR = AW'(OFF_ENCLR);
  localparam logic [AW-1:0] A_STAT  = AW'(OFF_STAT);
  localparam logic [AW-1:0] A_VECP  = AW'(OFF_VECP);

  logic [NSRC-1:0] en;
  logic [NSRC-1:0] status;
  logic [DW-1:0]   vec;
  logic [EOIW-1:0] eoi_field;
  logic            set_we, clr_we, eoi_we;

  assign set_we = reg_wen && (reg_addr == A_ENSET);
  assign clr_we = reg_wen && (reg_addr == A_ENCLR);
  assign eoi_we = reg_wen && (reg_addr == A_EOI);
  assign status = src_pend & en;

  irq_enable_reg #(.NSRC(NSRC)) u_en (
    .clk(clk), .rst(rst), .set_we(set_we), .clr_we(clr_we),
    .wbits(reg_wdata[NSRC-1:0]), .en(en)
  );

  irq_vec_enc #(.NSRC(NSRC), .VW(DW)) u_vec (
    .active(status), .vec(vec)
  );

  irq_pulse_gen #(.NSRC(NSRC)) u_pulse (
    .clk(clk), .rst(rst), .status(status), .eoi_we(eoi_we),
    .irq_pulse(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst) eoi_field <= '0;
    else if (eoi_we) eoi_field <= reg_wdata[EOIW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        A_REV:           reg_rdata <= REV_WORD;
        A_EOI:           reg_rdata <= DW'(eoi_field);
        A_VEC, A_VECP:   reg_rdata <= vec;
        A_ENSET, A_ENCLR: reg_rdata <= DW'(en);
        A_STAT:          reg_rdata <= DW'(status);
        default:         reg_rdata <= '0;
      endcase
    end
  end

  a_r7_vec_names_active: assert property (@(posedge clk) disable iff (rst)
    (vec != '0) |-> status[vec - 1]);
  a_r7_vec_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> (vec == '0));
  a_r10_rev_read: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == A_REV) |=> (reg_rdata == REV_WORD));
endmodule

// File: tb/pulse_irq_agg_tb_top.sv
module pulse_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  src_pend = '0;
  logic        reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_pulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [2:0] m_en;
  logic       m_armed;
  logic [7:0] m_eoi;

  always #4 clk = ~clk;

  pulse_irq_agg dut_i (
    .clk(clk), .rst(rst), .src_pend(src_pend), .reg_wen(reg_wen),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pulse(irq_pulse)
  );

  function automatic logic [31:0] exp_vec(input logic [2:0] act);
    if (act[0]) return 32'd1;
    if (act[1]) return 32'd2;
    if (act[2]) return 32'd3;
    return 32'd0;
  endfunction

  function automatic logic [31:0] exp_read(input logic [11:0] a, input logic [2:0] pend);
    case (a)
      12'h000: return 32'h6690A200;
      12'h010: return {24'd0, m_eoi};
      12'h014, 12'hA80: return exp_vec(pend & m_en);
      12'h100, 12'h300: return {29'd0, m_en};
      12'h500: return {29'd0, pend & m_en};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [11:0] a);
    case (a)
      12'h000: return "R8";
      12'h010: return "R6";
      12'h014, 12'hA80: return "R7";
      12'h100: return "R2";
      12'h300: return "R3";
      12'h500: return "R4";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One lockstep cycle: drive at negedge, predict, check at next negedge (R10 timing)
  task automatic step(input logic [2:0] pend, input logic wen,
                      input logic [11:0] a, input logic [31:0] wd);
    logic [2:0]  st;
    logic        fire;
    logic [31:0] erd;
    st   = pend & m_en;
    erd  = exp_read(a, pend);
    fire = m_armed && (st != 3'd0);
    if (fire) m_armed = 1'b0;
    else if (wen && a == 12'h010) m_armed = 1'b1;
    if (wen && a == 12'h100) m_en = m_en | wd[2:0];
    else if (wen && a == 12'h300) m_en = m_en & ~wd[2:0];
    if (wen && a == 12'h010) m_eoi = wd[7:0];
    src_pend = pend; reg_wen = wen; reg_addr = a; reg_wdata = wd;
    @(negedge clk);
    check("R5", {31'd0, irq_pulse}, {31'd0, fire});
    check({req_of(a), "/R10"}, reg_rdata, erd);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [8];
    void'($urandom(32'h1F2E3D4C));
    addrs = '{12'h000, 12'h010, 12'h014, 12'h100, 12'h300, 12'h500, 12'hA80, 12'h104};
    m_en = '0; m_armed = 1'b1; m_eoi = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1", reg_rdata, 32'd0);
    check("R1", {31'd0, irq_pulse}, 32'd0);
    foreach (addrs[i]) step(3'b111, 1'b0, addrs[i], 32'd0);
    // R2 zeros do not clear, R3 selective clear
    step(3'b000, 1'b1, 12'h100, 32'hFFFF_FFF5);
    step(3'b000, 1'b1, 12'h100, 32'h0000_0002);
    step(3'b000, 1'b0, 12'h100, 32'd0);
    step(3'b000, 1'b1, 12'h300, 32'h0000_0005);
    step(3'b000, 1'b0, 12'h300, 32'd0);
    // R9 unmapped write ignored
    step(3'b000, 1'b1, 12'h7FC, 32'hFFFF_FFFF);
    step(3'b000, 1'b0, 12'h100, 32'd0);
    // R5 pulse then disarm, R7 lowest wins
    step(3'b000, 1'b1, 12'h100, 32'h7);
    step(3'b110, 1'b0, 12'h014, 32'd0);
    step(3'b110, 1'b0, 12'hA80, 32'd0);
    step(3'b110, 1'b0, 12'h500, 32'd0);
    // R6 EOI while pending re-fires next cycle
    step(3'b110, 1'b1, 12'h010, 32'hABCD_EF5A);
    step(3'b110, 1'b0, 12'h010, 32'd0);
    step(3'b000, 1'b0, 12'h000, 32'd0);
    // R6 EOI when idle: no pulse until a source rises
    step(3'b000, 1'b1, 12'h010, 32'h33);
    step(3'b000, 1'b0, 12'h000, 32'd0);
    step(3'b100, 1'b0, 12'h014, 32'd0);
    step(3'b100, 1'b0, 12'h014, 32'd0);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [2:0]  p;
      logic        w;
      logic [11:0] a;
      p = ($urandom % 4 == 0) ? 3'($urandom) : src_pend;
      w = ($urandom % 10) < 4;
      a = ($urandom % 9 == 8) ? 12'($urandom) : addrs[$urandom % 8];
      step(p, w, a, $urandom);
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule